// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a NOR-style flash bus. It decides when an embedded program or erase operation inside the device has finished. Once the command sequence has gone out, the host pulses `start_i` with the address to watch. The poller then reads the 8-bit status word at that address in back-to-back pairs. The device flips its toggle bit on every status read while the operation runs. A pair whose toggle bits agree therefore means the operation has finished.

While the operation runs, the poller also watches the timeout-failure flag. When that flag is up, it does not judge on the first pair. It reads a second pair, because the toggle bit can stop flipping in the same read where the flag rises. A toggle bit that still flips on this recheck means the operation failed. The poller then writes the reset command so the device goes back to array reads. A bounded number of busy pairs guards against a hung device and ends in a separate timeout result, also after the reset write.

Bus transfers use a request/acknowledge handshake, so any number of wait states is allowed. The host may abandon polling at any time with `abort_i`. A later start always begins again with a fresh first pair and a fresh poll budget.

Top module: `tglpoll_ctrl`

## Requirements
- R1: Out of reset the poller makes no bus request, and `done_o`, `pass_o`, `fail_o` and `tmo_o` are all low.
- R2: After `start_i` in idle, every read goes to the address captured with that start. Each request stays up, with address and direction unchanged, until the cycle in which `mem_ack_i` is high.
- R3: When the toggle bit (bit 6 of the status word) has the same value in both reads of a pair, the poller reports success and issues no write.
- R4: When the toggle bits of a pair differ and the failure flag (bit 5) is 0 in both reads, the poller starts another pair of reads.
- R5: When the toggle bits of a pair differ and bit 5 is 1 in either read, the poller reads exactly one more pair. If the toggle bits of that recheck pair agree, it reports success with no write.
- R6: When the recheck pair still toggles, the poller writes 0xF0 to the polled address, then reports failure.
- R7: After MAX_POLLS consecutive busy pairs (toggling, bit 5 clear), the poller writes 0xF0 to the polled address, then reports timeout with `fail_o` low.
- R8: `abort_i` during reading returns the poller to idle with no report. The next start begins with a new first pair and a full poll budget.
- R9: `start_i` while an operation is being polled has no effect on the reads or the result.
- R10: Each report is `done_o` high for one clock with exactly one of `pass_o`, `fail_o`, `tmo_o`. Those three are low whenever `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin polling (honoured only when idle) |
| abort_i | input | 1 | Abandon polling and return to idle |
| poll_addr_i | input | AW | Address of the status word, captured at start |
| mem_req_o | output | 1 | Bus transfer request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Transfer address |
| mem_wdata_o | output | DW | Write data (reset command) |
| mem_ack_i | input | 1 | Transfer completes in this cycle |
| mem_rdata_i | input | DW | Read data, valid with acknowledge |
| done_o | output | 1 | One-cycle completion strobe |
| pass_o | output | 1 | Operation finished successfully |
| fail_o | output | 1 | Operation failed; reset command sent |
| tmo_o | output | 1 | Poll budget exhausted; reset command sent |

## Verification
The handshake assertion assumes the bus model never withdraws an acknowledge and never acknowledges without a request. It also assumes that `abort_i` and `mem_ack_i` are not both high in the same cycle. The bench's bus model acknowledges only a live request, after a pseudo-random wait of zero to three cycles. It holds acknowledge low in any cycle where it raises abort. Status words from the bench carry noise in every bit except 6 and 5, and each pair is built to match the device's toggling. Every sequence therefore ends in a defined outcome before the stored words run out.

// File: rtl/tglpoll_pkg.sv
package tglpoll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_CHK_A,
        ST_CHK_B,
        ST_RSTW,
        ST_FIN
    } st_e;

    typedef enum logic [1:0] {
        VD_PASS,
        VD_AGAIN,
        VD_RECHK,
        VD_FAIL
    } verdict_e;

    typedef enum logic [1:0] {
        RS_NONE,
        RS_PASS,
        RS_FAIL,
        RS_TMO
    } result_e;

    typedef struct packed {
        logic tgl;
        logic err;
    } flag_s;

    // states that drive a status read on the bus
    function automatic logic is_read(st_e s);
        return (s == ST_RD_A) || (s == ST_RD_B) || (s == ST_CHK_A) || (s == ST_CHK_B);
    endfunction

    // states that hold the first read of a pair
    function automatic logic is_first(st_e s);
        return (s == ST_RD_A) || (s == ST_CHK_A);
    endfunction

endpackage

// File: rtl/tglpoll_judge.sv
module tglpoll_judge
    import tglpoll_pkg::*;
#(
    parameter bit ERR_ANY = 1'b1
) (
    input  flag_s    first_i,
    input  flag_s    second_i,
    input  logic     recheck_i,
    output verdict_e verdict_o
);
    logic moved;
    logic flagged;

    assign moved = first_i.tgl ^ second_i.tgl;

    generate
        if (ERR_ANY) begin : g_err_any
            assign flagged = first_i.err | second_i.err;
        end else begin : g_err_last
            assign flagged = second_i.err;
        end
    endgenerate

    always_comb begin
        if (!moved)          verdict_o = VD_PASS;
        else if (recheck_i)  verdict_o = VD_FAIL;
        else if (flagged)    verdict_o = VD_RECHK;
        else                 verdict_o = VD_AGAIN;
    end
endmodule

// File: rtl/tglpoll_budget.sv
module tglpoll_budget #(
    parameter int MAX_POLLS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic bump_i,
    output logic last_o
);
    localparam int CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) cnt_q <= '0;
        else if (bump_i)  cnt_q <= cnt_q + 1'b1;
    end

    assign last_o = (cnt_q == LAST);

    a_r7_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    a_r7_bump_counts: assert property (@(posedge clk) disable iff (rst)
        (bump_i && !clr_i && !last_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

    a_r8_clear_restarts: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/tglpoll_ctrl.sv
module tglpoll_ctrl
    import tglpoll_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 8,
    parameter int TGL_BIT   = 6,
    parameter int ERR_BIT   = 5,
    parameter int MAX_POLLS = 16,
    parameter bit ERR_ANY   = 1'b1,
    parameter logic [DW-1:0] RST_DATA = DW'(8'hF0)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          abort_i,
    input  logic [AW-1:0] poll_addr_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic          mem_ack_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          done_o,
    output logic          pass_o,
    output logic          fail_o,
    output logic          tmo_o
);
    st_e           st_q, st_d;
    result_e       res_q, res_d;
    flag_s         first_q, cur_flags;
    logic [AW-1:0] addr_q;
    logic          cap_en, bump, clr, budget_last;
    verdict_e      verdict;
    logic          unused_rdata_bits;

    assign cur_flags = '{tgl: mem_rdata_i[TGL_BIT], err: mem_rdata_i[ERR_BIT]};
    assign unused_rdata_bits = ^mem_rdata_i;

    tglpoll_judge #(.ERR_ANY(ERR_ANY)) u_judge (
        .first_i   (first_q),
        .second_i  (cur_flags),
        .recheck_i (st_q == ST_CHK_B),
        .verdict_o (verdict)
    );

    tglpoll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr),
        .bump_i (bump),
        .last_o (budget_last)
    );

    always_comb begin
        st_d   = st_q;
        res_d  = res_q;
        cap_en = 1'b0;
        bump   = 1'b0;
        clr    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_d  = ST_RD_A;
                    res_d = RS_NONE;
                    clr   = 1'b1;
                end
            end
            ST_RD_A, ST_CHK_A: begin
                if (abort_i) begin
                    st_d = ST_IDLE;
                end else if (mem_ack_i) begin
                    cap_en = 1'b1;
                    st_d   = (st_q == ST_RD_A) ? ST_RD_B : ST_CHK_B;
                end
            end
            ST_RD_B, ST_CHK_B: begin
                if (abort_i) begin
                    st_d = ST_IDLE;
                end else if (mem_ack_i) begin
                    unique case (verdict)
                        VD_PASS: begin
                            res_d = RS_PASS;
                            st_d  = ST_FIN;
                        end
                        VD_RECHK: st_d = ST_CHK_A;
                        VD_FAIL: begin
                            res_d = RS_FAIL;
                            st_d  = ST_RSTW;
                        end
                        default: begin
                            if (budget_last) begin
                                res_d = RS_TMO;
                                st_d  = ST_RSTW;
                            end else begin
                                bump = 1'b1;
                                st_d = ST_RD_A;
                            end
                        end
                    endcase
                end
            end
            ST_RSTW: if (mem_ack_i) st_d = ST_FIN;
            ST_FIN:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            res_q   <= RS_NONE;
            first_q <= '0;
            addr_q  <= '0;
        end else begin
            st_q  <= st_d;
            res_q <= res_d;
            if (cap_en) first_q <= cur_flags;
            if (st_q == ST_IDLE && start_i) addr_q <= poll_addr_i;
        end
    end

    assign mem_req_o   = is_read(st_q) || (st_q == ST_RSTW);
    assign mem_we_o    = (st_q == ST_RSTW);
    assign mem_addr_o  = addr_q;
    assign mem_wdata_o = (st_q == ST_RSTW) ? RST_DATA : '0;
    assign done_o      = (st_q == ST_FIN);
    assign pass_o      = done_o && (res_q == RS_PASS);
    assign fail_o      = done_o && (res_q == RS_FAIL);
    assign tmo_o       = done_o && (res_q == RS_TMO);

    a_r2_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i && !abort_i) |=>
            (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o)));

    a_r2_pair_order: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && is_first(st_q) && mem_ack_i && !abort_i) |=> (mem_req_o && !mem_we_o));

    a_r3_pass_after_read: assert property (@(posedge clk) disable iff (rst)
        pass_o |-> $past(mem_req_o && !mem_we_o && mem_ack_i));

    a_r6_fail_after_write: assert property (@(posedge clk) disable iff (rst)
        (fail_o || tmo_o) |-> $past(mem_req_o && mem_we_o && mem_ack_i));

    a_r10_one_result: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $onehot({pass_o, fail_o, tmo_o}));

    a_r10_quiet_flags: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> !(pass_o || fail_o || tmo_o));

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !mem_req_o));
endmodule

// File: tb/sim_tglpoll_ctrl.sv
`timescale 1ns/1ps
module sim_tglpoll_ctrl;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int MAXP = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          start_i = 1'b0, abort_i = 1'b0, mem_ack_i = 1'b0;
    logic [AW-1:0] poll_addr_i = '0;
    logic [DW-1:0] mem_rdata_i = '0;
    logic          mem_req_o, mem_we_o, done_o, pass_o, fail_o, tmo_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o;

    tglpoll_ctrl #(.AW(AW), .DW(DW), .MAX_POLLS(MAXP)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .abort_i(abort_i),
        .poll_addr_i(poll_addr_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
        .mem_rdata_i(mem_rdata_i), .done_o(done_o), .pass_o(pass_o),
        .fail_o(fail_o), .tmo_o(tmo_o)
    );

    int compared = 0, mismatched = 0, cyc = 0, waitc = 0;
    int rd_cnt = 0, wr_cnt = 0, exp_reads = 0, exp_res = 0;
    bit exp_wr = 0, allow_done = 0, done_seen = 0, abort_req = 0, live = 0;
    bit last_we = 0;
    logic [7:0] last_wd = '0;
    logic [AW-1:0] exp_addr = '0;
    int unsigned lfsr = 32'h1357_9BDF;
    logic [7:0] q[$];
    string tag = "R1";

    function automatic void chk(bit ok, string t, string what, longint act, longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
        end
    endfunction

    function automatic void add_pair(bit ta, bit tb, bit ea, bit eb);
        lfsr = lfsr * 32'd1103515245 + 32'd12345;
        q.push_back({lfsr[20], ta, ea, lfsr[27:23]});
        q.push_back({lfsr[15], tb, eb, lfsr[12:8]});
    endfunction

    // behavioural model of the polling outcome for the stored status words
    function automatic void predict();
        int i = 0;
        int busy = 0;
        logic [7:0] a, b, c, d;
        while (1) begin
            a = q[i]; b = q[i+1]; i += 2;
            if (a[6] == b[6]) begin exp_res = 0; exp_wr = 0; break; end
            if (a[5] || b[5]) begin
                c = q[i]; d = q[i+1]; i += 2;
                exp_res = (c[6] == d[6]) ? 0 : 1;
                exp_wr  = (exp_res != 0);
                break;
            end
            busy++;
            if (busy == MAXP) begin exp_res = 2; exp_wr = 1; break; end
        end
        exp_reads = i;
    endfunction

    always @(negedge clk) begin
        cyc++;
        lfsr = lfsr * 32'd69069 + 32'd1;
        if (!rst && live) begin
            if (mem_ack_i) begin
                if (last_we) begin
                    wr_cnt++;
                    chk(last_wd == 8'hF0, tag, "reset command data", last_wd, 8'hF0);
                end else begin
                    rd_cnt++;
                    if (q.size() > 0) void'(q.pop_front());
                end
            end
            if (mem_req_o) begin
                chk(mem_addr_o == exp_addr, "R2", "address", mem_addr_o, exp_addr);
                if (rd_cnt < exp_reads)
                    chk(!mem_we_o, tag, "read expected", mem_we_o, 0);
                else if (exp_wr && wr_cnt == 0)
                    chk(mem_we_o, tag, "reset write expected", mem_we_o, 1);
                else
                    chk(0, tag, "unexpected request", 1, 0);
            end
            if (done_o) begin
                chk(allow_done, tag, "report allowed", 1, allow_done);
                chk($onehot({pass_o, fail_o, tmo_o}), "R10", "one result", {pass_o, fail_o, tmo_o}, 1);
                chk(pass_o == (exp_res == 0), tag, "pass", pass_o, exp_res == 0);
                chk(fail_o == (exp_res == 1), tag, "fail", fail_o, exp_res == 1);
                chk(tmo_o == (exp_res == 2), tag, "timeout", tmo_o, exp_res == 2);
                chk(rd_cnt == exp_reads, tag, "read count", rd_cnt, exp_reads);
                chk(wr_cnt == (exp_wr ? 1 : 0), tag, "write count", wr_cnt, exp_wr);
                done_seen  = 1;
                allow_done = 0;
            end else begin
                chk(!(pass_o || fail_o || tmo_o), "R10", "flags without done",
                    {pass_o, fail_o, tmo_o}, 0);
            end
            last_we = mem_we_o;
            last_wd = mem_wdata_o;
            if (abort_req) begin
                abort_i   = 1'b1;
                abort_req = 0;
                mem_ack_i = 1'b0;
            end else begin
                abort_i = 1'b0;
                if (mem_req_o && waitc == 0) begin
                    mem_ack_i   = 1'b1;
                    mem_rdata_i = mem_we_o ? 8'h00 : ((q.size() > 0) ? q[0] : 8'h00);
                    waitc       = lfsr[9:8];
                end else begin
                    mem_ack_i = 1'b0;
                    if (mem_req_o && waitc > 0) waitc--;
                end
            end
        end
        if (cyc > 150000) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic pulse_start(logic [AW-1:0] addr);
        @(negedge clk);
        poll_addr_i = addr;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        poll_addr_i = ~addr;
    endtask

    task automatic run(string t, logic [AW-1:0] addr, int glitch_at);
        int g = glitch_at;
        tag = t;
        predict();
        rd_cnt = 0; wr_cnt = 0; done_seen = 0; allow_done = 1; exp_addr = addr;
        pulse_start(addr);
        while (!done_seen) begin
            @(negedge clk);
            if (g >= 0 && rd_cnt >= g) begin start_i = 1'b1; g = -1; end
            else start_i = 1'b0;
        end
        start_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_req_o, "R1", "request after reset", mem_req_o, 0);
        chk(!(done_o || pass_o || fail_o || tmo_o), "R1", "reports after reset",
            {done_o, pass_o, fail_o, tmo_o}, 0);
        live = 1;

        // R3: settled on the first pair
        q.delete(); add_pair(1, 1, 0, 0);
        run("R3", 16'h1000, -1);

        // R4: several busy pairs, then settled
        q.delete();
        for (int i = 0; i < 3; i++) add_pair(0, 1, 0, 0);
        add_pair(0, 0, 0, 0);
        run("R4", 16'h2004, -1);

        // R5: flag in the second read, recheck settles
        q.delete(); add_pair(0, 1, 0, 1); add_pair(1, 1, 1, 1);
        run("R5", 16'h3008, -1);

        // R5: flag only in the first read still forces a recheck
        q.delete(); add_pair(1, 0, 1, 0); add_pair(0, 0, 0, 0);
        run("R5", 16'h300C, -1);

        // R6: recheck still toggling
        q.delete(); add_pair(0, 1, 0, 1); add_pair(0, 1, 1, 1);
        run("R6", 16'h4010, -1);

        // R7: budget exhausted
        q.delete();
        for (int i = 0; i < MAXP; i++) add_pair(0, 1, 0, 0);
        run("R7", 16'h5014, -1);

        // R9: start pulsed mid-operation is ignored
        q.delete();
        for (int i = 0; i < 5; i++) add_pair(0, 1, 0, 0);
        add_pair(0, 1, 0, 1); add_pair(0, 1, 1, 1);
        run("R9", 16'h6018, 3);

        // R8: abandon mid-pair, then restart from scratch
        tag = "R8";
        q.delete();
        for (int i = 0; i < 20; i++) add_pair(0, 1, 0, 0);
        exp_reads = 1000; exp_wr = 0; exp_res = 0;
        rd_cnt = 0; wr_cnt = 0; done_seen = 0; allow_done = 0; exp_addr = 16'h701C;
        pulse_start(16'h701C);
        while (rd_cnt < 7) @(negedge clk);
        abort_req = 1;
        repeat (5) @(negedge clk);
        chk(!mem_req_o, "R8", "request after abort", mem_req_o, 0);
        chk(!done_seen, "R8", "report after abort", done_seen, 0);
        q.delete();
        for (int i = 0; i < MAXP; i++) add_pair(0, 1, 0, 0);
        run("R8", 16'h7020, -1);

        // R2: long run with a settled finish at another address
        q.delete();
        for (int i = 0; i < MAXP - 1; i++) add_pair(1, 0, 0, 0);
        add_pair(1, 1, 0, 0);
        run("R2", 16'hFFFE, -1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule